// File: doc/BRIEF.md
# Byte/Word Arithmetic and Shift Unit with Status Flags

This block computes add, subtract, increment, shift and rotate results on 8-bit or 16-bit operands. It also produces the 16-bit status word that goes with each result. The caller sets an operation code, the operands and the size controls, then pulses `start` for one cycle. Add, subtract and increment finish in one cycle. Shifts and rotates move one bit per clock: `busy` stays high while the unit steps, and `done` pulses for one cycle when `result` and `flags_out` are valid.

The size bit picks the active width. In byte mode every flag is taken from bits 7:0 and the upper result byte is forced to zero. A sign-extend control widens an 8-bit immediate for word operations. A count-select bit chooses a shift count of one or the value on the count port. Control flags and the unused bit positions of the status word are copied from the incoming status word.

Top module: `bw_alu`

## Requirements
- R1: Operation codes on `op_sel` are 0 add, 1 subtract, 2 increment, 3 shift left, 4 logical shift right, 5 rotate left and 6 rotate right. An add or subtract makes `done` high one cycle after `start`, and the sum or difference then appears on `result`.
- R2: For add, subtract and increment, the carry bit (bit 0) is the carry out of the top active bit, or for subtract the borrow into it. The auxiliary bit (bit 4) is the carry or borrow between bit 3 and bit 4. The overflow bit (bit 11) is set on signed overflow at the active width.
- R3: Increment adds one and sets bits 2, 4, 6, 7 and 11 like an add, but bit 0 keeps the value it had in `flags_in`.
- R4: When `wide`=1 and `sext`=1, the add/subtract operand `opb[7:0]` is sign-extended to 16 bits. When `wide`=1 and `sext`=0, all 16 bits of `opb` are used.
- R5: An add or subtract started with `sext`=1 and `wide`=0 raises `size_err` together with `done`. Every other completion leaves `size_err` low.
- R6: When `wide`=0, `result[15:8]` is zero and every flag is computed from bits 7:0 only.
- R7: The zero bit (bit 6) marks a zero result, the sign bit (bit 7) copies the top active result bit, and the parity bit (bit 2) is set when `result[7:0]` holds an even number of ones. Bits 15:12, 10:8, 5, 3 and 1 are copied from `flags_in`.
- R8: For shifts and rotates, `cnt_sel`=0 gives a count of one and `cnt_sel`=1 takes the count from `cl_cnt`.
- R9: A shift or rotate of count N≥1 holds `busy` high for N cycles and raises `done` N+1 cycles after `start`. `busy` and `done` are never high together.
- R10: A shift or rotate of count 0 raises `done` one cycle after `start`. It returns `opa` at the active width and `flags_in` unchanged.
- R11: `start` is ignored while `busy` is high, and the running operation finishes with its own inputs.
- R12: Each shift step sets bit 0 to the bit moved out. Left shifts and both rotates set bit 11 to the new top bit XOR the new carry, except right rotate, which uses the XOR of the two top result bits. Logical shift right sets bit 11 to the top bit before the step. Shifts update bits 2, 6 and 7 and keep bit 4. Rotates keep bits 2, 4, 6 and 7.
- R13: After reset, `result`, `flags_out`, `busy`, `done` and `size_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op_sel | input | 3 | Operation code |
| wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| sext | input | 1 | Sign-extend the 8-bit immediate for word operations |
| cnt_sel | input | 1 | 0 = count of one, 1 = count from `cl_cnt` |
| cl_cnt | input | CNT_W | Shift/rotate count register value |
| opa | input | 16 | First operand / value to shift |
| opb | input | 16 | Second operand or immediate |
| flags_in | input | 16 | Incoming status word |
| result | output | 16 | Result, valid while `done` is high |
| flags_out | output | 16 | Updated status word |
| busy | output | 1 | Shift/rotate is stepping |
| done | output | 1 | One-cycle completion pulse |
| size_err | output | 1 | Invalid sign-extend/byte size combination |

## Verification
The assertions assume that `op_sel`, `wide`, `flags_in` and `opa` are stable in the cycle when `start` is sampled. The checks on carry preservation and zero-count passthrough compare the registered output against the inputs of that one cycle. The bench drives every input on the falling edge and holds it until the next falling edge, so each input is sampled at exactly one rising edge. During the busy-window test the bench changes the operands and raises `start` again. It does this only while `busy` is high, because that is the stimulus R11 covers.

// File: rtl/bw_alu_pkg.sv
package bw_alu_pkg;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  // status word bit positions
  localparam int FB_C = 0;
  localparam int FB_P = 2;
  localparam int FB_A = 4;
  localparam int FB_Z = 6;
  localparam int FB_S = 7;
  localparam int FB_O = 11;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_INC = 3'd2,
    OP_SHL = 3'd3,
    OP_SHR = 3'd4,
    OP_ROL = 3'd5,
    OP_ROR = 3'd6,
    OP_NOP = 3'd7
  } alu_op_e;

  function automatic logic [WORD_W-1:0] fit(input logic [WORD_W-1:0] v, input logic wide);
    return wide ? v : {{(WORD_W-BYTE_W){1'b0}}, v[BYTE_W-1:0]};
  endfunction

  function automatic logic top_bit(input logic [WORD_W-1:0] v, input logic wide);
    return wide ? v[WORD_W-1] : v[BYTE_W-1];
  endfunction

  function automatic logic next_bit(input logic [WORD_W-1:0] v, input logic wide);
    return wide ? v[WORD_W-2] : v[BYTE_W-2];
  endfunction

  function automatic logic even_ones(input logic [WORD_W-1:0] v);
    return ~^v[BYTE_W-1:0];
  endfunction

  function automatic logic all_zero(input logic [WORD_W-1:0] v, input logic wide);
    return fit(v, wide) == '0;
  endfunction

  function automatic logic is_shift(input alu_op_e op);
    return (op == OP_SHL) || (op == OP_SHR) || (op == OP_ROL) || (op == OP_ROR);
  endfunction

endpackage

// File: rtl/bw_alu_arith.sv
module bw_alu_arith
  import bw_alu_pkg::*;
(
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  alu_op_e           op,
  input  logic              wide,
  input  logic              sext,
  output logic [WORD_W-1:0] res,
  output logic              cy,
  output logic              aux,
  output logic              ovf,
  output logic              size_bad
);

  logic [WORD_W-1:0] b_ext, rhs, am, bm;
  logic [WORD_W:0]   full;
  logic              sa, sb, sr;

  always_comb begin
    b_ext = (sext && wide) ? {{(WORD_W-BYTE_W){b[BYTE_W-1]}}, b[BYTE_W-1:0]} : b;
    rhs   = (op == OP_INC) ? WORD_W'(1) : b_ext;
    am    = fit(a, wide);
    bm    = fit(rhs, wide);
    if (op == OP_SUB) full = {1'b0, am} - {1'b0, bm};
    else              full = {1'b0, am} + {1'b0, bm};
    res   = fit(full[WORD_W-1:0], wide);
    cy    = wide ? full[WORD_W] : full[BYTE_W];
    aux   = am[4] ^ bm[4] ^ full[4];
    sa    = top_bit(am, wide);
    sb    = top_bit(bm, wide);
    sr    = top_bit(res, wide);
    ovf   = (op == OP_SUB) ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
    size_bad = sext && !wide && ((op == OP_ADD) || (op == OP_SUB));
  end

  // R6: byte mode never leaks into the upper half
  always_comb begin
    if (!wide) a_r6_arith_byte_clean : assert (res[WORD_W-1:BYTE_W] == '0);
  end

endmodule

// File: rtl/bw_alu_status.sv
module bw_alu_status
  import bw_alu_pkg::*;
(
  input  logic [WORD_W-1:0] base,
  input  logic [WORD_W-1:0] res,
  input  logic              wide,
  input  logic              cy,
  input  logic              aux,
  input  logic              ovf,
  input  logic              keep_cy,
  output logic [WORD_W-1:0] packed_flags
);

  always_comb begin
    packed_flags       = base;
    packed_flags[FB_C] = keep_cy ? base[FB_C] : cy;
    packed_flags[FB_A] = aux;
    packed_flags[FB_O] = ovf;
    packed_flags[FB_S] = top_bit(res, wide);
    packed_flags[FB_Z] = all_zero(res, wide);
    packed_flags[FB_P] = even_ones(res);
  end

endmodule

// File: rtl/bw_alu_shstep.sv
module bw_alu_shstep
  import bw_alu_pkg::*;
(
  input  logic [WORD_W-1:0] val,
  input  alu_op_e           op,
  input  logic              wide,
  input  logic [WORD_W-1:0] fin,
  output logic [WORD_W-1:0] vn,
  output logic [WORD_W-1:0] fout
);

  logic [WORD_W-1:0] v;
  logic              hi, lo;

  always_comb begin
    v    = fit(val, wide);
    hi   = top_bit(v, wide);
    lo   = v[0];
    vn   = v;
    fout = fin;
    case (op)
      OP_SHL: begin
        vn = fit(v << 1, wide);
        fout[FB_C] = hi;
        fout[FB_O] = top_bit(vn, wide) ^ hi;
      end
      OP_SHR: begin
        vn = v >> 1;
        fout[FB_C] = lo;
        fout[FB_O] = hi;
      end
      OP_ROL: begin
        vn = fit({v[WORD_W-2:0], hi}, wide);
        fout[FB_C] = hi;
        fout[FB_O] = top_bit(vn, wide) ^ hi;
      end
      OP_ROR: begin
        vn = wide ? {lo, v[WORD_W-1:1]}
                  : {{(WORD_W-BYTE_W){1'b0}}, lo, v[BYTE_W-1:1]};
        fout[FB_C] = lo;
        fout[FB_O] = top_bit(vn, wide) ^ next_bit(vn, wide);
      end
      default: ;
    endcase
    if (op == OP_SHL || op == OP_SHR) begin
      fout[FB_S] = top_bit(vn, wide);
      fout[FB_Z] = all_zero(vn, wide);
      fout[FB_P] = even_ones(vn);
    end
  end

endmodule

// File: rtl/bw_alu.sv
module bw_alu
  import bw_alu_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op_sel,
  input  logic              wide,
  input  logic              sext,
  input  logic              cnt_sel,
  input  logic [CNT_W-1:0]  cl_cnt,
  input  logic [15:0]       opa,
  input  logic [15:0]       opb,
  input  logic [15:0]       flags_in,
  output logic [15:0]       result,
  output logic [15:0]       flags_out,
  output logic              busy,
  output logic              done,
  output logic              size_err
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  alu_op_e           op_in, op_q;
  logic              wide_q, busy_q, done_q, err_q;
  logic [WORD_W-1:0] acc_q, flg_q;
  logic [CNT_W-1:0]  rem_q, cnt_eff;

  logic [WORD_W-1:0] ar_res, st_flags, step_v, step_f;
  logic              ar_cy, ar_aux, ar_ovf, ar_bad;
  logic              launch, zero_shift;

  always_comb begin
    op_in      = alu_op_e'(op_sel);
    cnt_eff    = cnt_sel ? cl_cnt : ONE;
    launch     = start && !busy_q;
    zero_shift = launch && is_shift(op_in) && (cnt_eff == '0);
  end

  bw_alu_arith u_arith (
    .a(opa), .b(opb), .op(op_in), .wide(wide), .sext(sext),
    .res(ar_res), .cy(ar_cy), .aux(ar_aux), .ovf(ar_ovf), .size_bad(ar_bad)
  );

  bw_alu_status u_status (
    .base(flags_in), .res(ar_res), .wide(wide), .cy(ar_cy), .aux(ar_aux),
    .ovf(ar_ovf), .keep_cy(op_in == OP_INC), .packed_flags(st_flags)
  );

  bw_alu_shstep u_step (
    .val(acc_q), .op(op_q), .wide(wide_q), .fin(flg_q),
    .vn(step_v), .fout(step_f)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_ADD;
      wide_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      acc_q  <= '0;
      flg_q  <= '0;
      rem_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (busy_q) begin
        acc_q <= step_v;
        flg_q <= step_f;
        rem_q <= rem_q - ONE;
        if (rem_q == ONE) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start) begin
        op_q   <= op_in;
        wide_q <= wide;
        if (is_shift(op_in) || op_in == OP_NOP) begin
          acc_q <= fit(opa, wide);
          flg_q <= flags_in;
          if (op_in == OP_NOP || cnt_eff == '0) begin
            done_q <= 1'b1;
          end else begin
            busy_q <= 1'b1;
            rem_q  <= cnt_eff;
          end
        end else begin
          acc_q  <= ar_res;
          flg_q  <= st_flags;
          done_q <= 1'b1;
          err_q  <= ar_bad;
        end
      end
    end
  end

  assign result    = acc_q;
  assign flags_out = flg_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign size_err  = err_q;

  // R9: stepping and completion never overlap
  a_r9_busy_done_excl : assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !done_q);

  // R9: the count drains by one per cycle
  a_r9_rem_step : assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rem_q != ONE) |=> (busy_q && rem_q == $past(rem_q) - ONE));

  // R10: count of zero completes next cycle with inputs unchanged
  a_r10_zero_count : assert property (@(posedge clk) disable iff (!rst_n)
    zero_shift |=> (done_q && acc_q == $past(fit(opa, wide)) && flg_q == $past(flags_in)));

  // R3: increment keeps the incoming carry
  a_r3_inc_keeps_carry : assert property (@(posedge clk) disable iff (!rst_n)
    (launch && op_in == OP_INC) |=> (flg_q[FB_C] == $past(flags_in[FB_C])));

  // R6: byte results have a clean upper byte
  a_r6_byte_high_zero : assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !wide_q) |-> (acc_q[WORD_W-1:BYTE_W] == '0));

  // R11: a running operation keeps its own controls
  a_r11_hold_while_busy : assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (op_q == $past(op_q) && wide_q == $past(wide_q)));

  // R7: control bits pass untouched through stepping
  a_r7_ctrl_pass : assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (flg_q[10:8] == $past(flg_q[10:8])));

endmodule

// File: tb/bw_alu_tb.sv
`timescale 1ns/1ps
module bw_alu_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_sel = '0;
  logic        wide = 1'b0, sext = 1'b0, cnt_sel = 1'b0;
  logic [7:0]  cl_cnt = '0;
  logic [15:0] opa = '0, opb = '0, flags_in = '0;
  logic [15:0] result, flags_out;
  logic        busy, done, size_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bw_alu u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .wide(wide),
    .sext(sext), .cnt_sel(cnt_sel), .cl_cnt(cl_cnt), .opa(opa), .opb(opb),
    .flags_in(flags_in), .result(result), .flags_out(flags_out),
    .busy(busy), .done(done), .size_err(size_err)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic int ones8(input int v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += (v >> i) & 1;
    return c;
  endfunction

  // independent model for add/sub/inc, integer arithmetic
  function automatic logic [31:0] model_arith(input int op, input int a, input int b,
                                              input bit w, input bit s, input int fin);
    int width = w ? 16 : 8;
    int mask  = (1 << width) - 1;
    int half  = 1 << (width - 1);
    int av, bv, r, rm, sa, sb, sr;
    logic [15:0] f = fin[15:0];
    bit carry, aux, ovf;
    if (op == 2) bv = 1;
    else if (s && w) bv = ((b & 255) >= 128) ? ((b & 255) | 16'hff00) : (b & 255);
    else bv = b;
    av = a & mask;
    bv = bv & mask;
    r  = (op == 1) ? av - bv : av + bv;
    rm = r & mask;
    carry = (op == 1) ? (av < bv) : (r > mask);
    aux   = (op == 1) ? ((av & 15) < (bv & 15)) : (((av & 15) + (bv & 15)) > 15);
    sa = (av >= half) ? av - (mask + 1) : av;
    sb = (bv >= half) ? bv - (mask + 1) : bv;
    sr = (op == 1) ? sa - sb : sa + sb;
    ovf = (sr > half - 1) || (sr < -half);
    if (op != 2) f[0] = carry;
    f[2]  = (ones8(rm) % 2) == 0;
    f[4]  = aux;
    f[6]  = rm == 0;
    f[7]  = (rm >> (width - 1)) & 1;
    f[11] = ovf;
    return {rm[15:0], f};
  endfunction

  function automatic logic [31:0] model_shift(input int op, input int a, input bit w,
                                              input int n, input int fin);
    int width = w ? 16 : 8;
    int mask  = (1 << width) - 1;
    int v = a & mask;
    int hi, c;
    logic [15:0] f = fin[15:0];
    for (int i = 0; i < n; i++) begin
      hi = (v >> (width - 1)) & 1;
      if (op == 3) begin c = hi; v = (v << 1) & mask; f[11] = ((v >> (width-1)) & 1) ^ c; end
      else if (op == 4) begin c = v & 1; v = v >> 1; f[11] = hi; end
      else if (op == 5) begin c = hi; v = ((v << 1) | c) & mask; f[11] = ((v >> (width-1)) & 1) ^ c; end
      else begin c = v & 1; v = (v >> 1) | (c << (width - 1));
        f[11] = ((v >> (width-1)) & 1) ^ ((v >> (width-2)) & 1); end
      f[0] = c;
      if (op == 3 || op == 4) begin
        f[2] = (ones8(v) % 2) == 0;
        f[6] = v == 0;
        f[7] = (v >> (width - 1)) & 1;
      end
    end
    return {v[15:0], f};
  endfunction

  task automatic run(input int op, input int a, input int b, input bit w, input bit s,
                     input bit v, input int cl, input int fin,
                     output int r, output int f, output int cyc, output int bcnt, output int err);
    @(negedge clk);
    op_sel = op[2:0]; opa = a[15:0]; opb = b[15:0]; wide = w; sext = s;
    cnt_sel = v; cl_cnt = cl[7:0]; flags_in = fin[15:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1; bcnt = 0;
    while (!done && cyc < 400) begin
      if (busy) bcnt++;
      @(negedge clk);
      cyc++;
    end
    r = result; f = flags_out; err = size_err;
    if (!done) chk("timeout", 0, 1);
  endtask

  task automatic t_arith(input string tag, input int op, input int a, input int b,
                         input bit w, input bit s, input int fin);
    int r, f, cyc, bc, err;
    logic [31:0] e;
    e = model_arith(op, a, b, w, s, fin);
    run(op, a, b, w, s, 0, 0, fin, r, f, cyc, bc, err);
    chk({tag, " R1 latency"}, cyc, 1);
    chk({tag, " R1 result"}, r, e[31:16]);
    chk({tag, " R2 R7 flags"}, f, e[15:0]);
    chk({tag, " R5 size_err"}, err, (s && !w && op != 2) ? 1 : 0);
  endtask

  task automatic t_shift(input string tag, input int op, input int a, input bit w,
                         input bit v, input int cl, input int fin);
    int r, f, cyc, bc, err, n;
    logic [31:0] e;
    n = v ? cl : 1;  // R8
    e = model_shift(op, a, w, n, fin);
    run(op, a, 0, w, 0, v, cl, fin, r, f, cyc, bc, err);
    chk({tag, " R9 R8 latency"}, cyc, n + 1);
    chk({tag, " R9 busy cycles"}, bc, n);
    chk({tag, " R12 result"}, r, e[31:16]);
    chk({tag, " R12 flags"}, f, e[15:0]);
  endtask

  task automatic t_reset();
    chk("R13 result", result, 0);
    chk("R13 flags", flags_out, 0);
    chk("R13 busy", busy, 0);
    chk("R13 done", done, 0);
    chk("R13 size_err", size_err, 0);
  endtask

  task automatic t_zero_count();
    int r, f, cyc, bc, err;
    run(5, 16'hbeef, 0, 1, 0, 1, 0, 16'hf0d5, r, f, cyc, bc, err);
    chk("R10 latency", cyc, 1);
    chk("R10 result", r, 16'hbeef);
    chk("R10 flags", f, 16'hf0d5);
    run(3, 16'h12c3, 0, 0, 0, 1, 0, 16'h0001, r, f, cyc, bc, err);
    chk("R10 R6 byte result", r, 16'h00c3);
    chk("R10 byte flags", f, 16'h0001);
  endtask

  task automatic t_busy_ignore();
    int cyc;
    logic [31:0] e;
    e = model_shift(6, 16'h8421, 1, 4, 16'h0000);
    @(negedge clk);
    op_sel = 3'd6; opa = 16'h8421; wide = 1'b1; cnt_sel = 1'b1; cl_cnt = 8'd4;
    flags_in = 16'h0000; start = 1'b1;
    @(negedge clk);
    // R11: new request while busy
    op_sel = 3'd0; opa = 16'h1111; opb = 16'h2222; wide = 1'b0; cl_cnt = 8'd9;
    flags_in = 16'hffff; start = 1'b1;
    cyc = 1;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk("R11 latency", cyc, 5);
    chk("R11 result", result, e[31:16]);
    chk("R11 flags", flags_out, e[15:0]);
    @(negedge clk);
    chk("R11 no extra done", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_arith("add word", 0, 16'h55aa, 16'h1234, 1, 0, 16'h0000);
    t_arith("add wrap", 0, 16'hffff, 16'h0001, 1, 0, 16'hf700);
    t_arith("add byte ovf R6", 0, 16'h347f, 16'h5601, 0, 0, 16'h0000);
    t_arith("add byte hi R6", 0, 16'hab12, 16'hcd34, 0, 0, 16'h0a2a);
    t_arith("sub borrow", 1, 16'h0000, 16'h0001, 1, 0, 16'h0000);
    t_arith("sub byte ovf", 1, 16'h0080, 16'h0001, 0, 0, 16'h0001);
    t_arith("sub equal", 1, 16'h4321, 16'h4321, 1, 0, 16'h0000);
    t_arith("inc keep c R3", 2, 16'hffff, 0, 1, 0, 16'h0001);
    t_arith("inc keep nc R3", 2, 16'h00ff, 0, 0, 0, 16'h0000);
    t_arith("inc ovf R3", 2, 16'h7fff, 0, 1, 0, 16'h0001);
    t_arith("sext R4", 0, 16'h0100, 16'h00f0, 1, 1, 16'h0000);
    t_arith("nosext R4", 0, 16'h0100, 16'hfff0, 1, 0, 16'h0000);
    t_arith("sub sext R4", 1, 16'h0005, 16'h1280, 1, 1, 16'h0000);
    t_arith("bad size R5", 0, 16'h0010, 16'h0020, 0, 1, 16'h0000);
    t_shift("shl v0", 3, 16'hc001, 1, 0, 7, 16'h0000);
    t_shift("ror cl5", 6, 16'h1235, 1, 1, 5, 16'h0f00);
    t_shift("shr byte", 4, 16'hff96, 0, 1, 3, 16'h0000);
    t_shift("rol cl17", 5, 16'h8001, 1, 1, 17, 16'h0800);
    t_shift("ror byte", 6, 16'h0001, 0, 0, 0, 16'h0000);
    t_shift("shl byte out", 3, 16'h0081, 0, 1, 8, 16'h0010);
    t_zero_count();
    t_busy_ignore();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule